// File: doc/BRIEF.md
# Addressable Serial DAC Register Bank

This block is the digital front end of a twelve-channel 8-bit DAC. A host writes one channel at a time over a three-wire serial port: a serial clock, an active-low select and a data line. While the select is low, each rising edge of the serial clock shifts in one bit. Releasing the select commits the frame. The last twelve bits received are taken as a 4-bit channel address followed by an 8-bit value, and that value goes into the selected channel's latch. The twelve latch values drive the analog ladders directly.

All three serial lines and the two control inputs are brought into the system clock domain through synchronizers, and edges are found there. This means the serial clock must run well below the system clock. A separate active-low input forces every latch to half scale. A shutdown input passes through to a flag for the analog stages and never alters the latch contents.

Top module: `dac_serial_bank`

## Requirements
- R1: After the system reset every channel latch holds 0x80 and the shutdown flag is low.
- R2: A frame of exactly 12 bits carries the address in its first four bits and the value in its last eight, both MSB first. When the select rises, the channel whose index equals the address takes the value. Address 0 is the first channel, and address 11 is the last.
- R3: Serial clock edges while the select is high shift nothing, so no latch changes.
- R4: When more than 12 bits arrive in one frame, only the last 12 are decoded and the earlier bits are discarded.
- R5: A frame of fewer than 12 bits writes no latch.
- R6: A complete frame with an address from 12 to 15 writes no latch.
- R7: Holding the half-scale input low sets every latch to 0x80, and a later frame still writes normally.
- R8: The shutdown flag follows the shutdown input, and asserting or releasing shutdown leaves every latch value unchanged.
- R9: Frames received while shutdown is asserted update the latches as usual.
- R10: Each fall of the select starts a fresh bit count, so a short frame sent after a long one is still aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| cs_n | input | 1 | Active-low frame select; its rising edge commits the frame |
| sdi | input | 1 | Serial data, MSB first |
| mid_rst_n | input | 1 | Active-low request that sets all latches to half scale |
| shdn | input | 1 | Shutdown request |
| ch_level | output | 96 | Twelve 8-bit latch values; channel k occupies bits 8k+7 down to 8k |
| shdn_o | output | 1 | Synchronized shutdown flag for the analog stages |

## Verification
The hardest case to reach from the pins is a saturated bit counter that is still full when the next frame begins. If the counter were not cleared, a short frame following a long one would be taken as complete. The stimulus sends a 16-bit frame and then an 8-bit frame whose bits would decode to a valid write, and the bench expects no change. Writes issued under shutdown, and the addresses just past the last channel, are reached the same way: each is a deliberate frame, followed by a full bank comparison.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int FRAME_W  = ADDR_W + DATA_W;
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  localparam logic [DATA_W-1:0] MIDSCALE = 8'h80;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } dac_cmd_t;
endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      always_comb stg_d = d;
    end else begin : g_rest
      always_comb stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
  import dac_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             cs_s,
  input  logic             sdi_s,
  output logic             cs_rise,
  output logic             wr_en,
  output dac_cmd_t         wr_cmd,
  output logic [CNT_W-1:0] bit_cnt
);
  logic               sclk_d, cs_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               sclk_rise, cs_fall, shift_en;

  always_comb begin
    sclk_rise = sclk_s & ~sclk_d;
    cs_rise   = cs_s & ~cs_d;
    cs_fall   = ~cs_s & cs_d;
    shift_en  = ~cs_s & sclk_rise;
  end

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    if (cs_fall) begin
      cnt_d = '0;
    end else if (shift_en) begin
      shreg_d = {shreg_q[FRAME_W-2:0], sdi_s};
      if (cnt_q != CNT_W'(FRAME_W)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_d  <= sclk_s;
      cs_d    <= cs_s;
      if (shift_en) shreg_q <= shreg_d;
      if (cs_fall || shift_en) cnt_q <= cnt_d;
    end
  end

  always_comb begin
    wr_en   = cs_rise && (cnt_q == CNT_W'(FRAME_W));
    wr_cmd  = dac_cmd_t'(shreg_q);
    bit_cnt = cnt_q;
  end
endmodule

// File: rtl/dac_latch_bank.sv
module dac_latch_bank
  import dac_bank_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr_en,
  input  dac_cmd_t                 wr_cmd,
  output logic [NUM_CH*DATA_W-1:0] lat_flat
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [DATA_W-1:0] lat_q, lat_d;
    logic              hit, ld_en;

    always_comb begin
      hit   = wr_en && (wr_cmd.addr == ADDR_W'(i));
      ld_en = clr || hit;
      lat_d = clr ? MIDSCALE : wr_cmd.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lat_q <= MIDSCALE;
      else if (ld_en) lat_q <= lat_d;
    end

    assign lat_flat[i*DATA_W +: DATA_W] = lat_q;
  end
endmodule

// File: rtl/dac_serial_bank.sv
module dac_serial_bank
  import dac_bank_pkg::*;
#(
  parameter int NUM_CH      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk,
  input  logic                     cs_n,
  input  logic                     sdi,
  input  logic                     mid_rst_n,
  input  logic                     shdn,
  output logic [NUM_CH*DATA_W-1:0] ch_level,
  output logic                     shdn_o
);
  localparam int NIN = 5;
  // bit order: {shdn, mid_rst_n, sdi, cs_n, sclk}
  localparam logic [NIN-1:0] IN_RST = 5'b01010;

  logic [NIN-1:0]   raw_in, sync_in;
  logic             sclk_s, cs_s, sdi_s, mid_n_s, shdn_s;
  logic             cs_rise, wr_en, clr;
  dac_cmd_t         wr_cmd;
  logic [CNT_W-1:0] bit_cnt;

  assign raw_in = {shdn, mid_rst_n, sdi, cs_n, sclk};

  dac_in_sync #(.W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
  );

  assign {shdn_s, mid_n_s, sdi_s, cs_s, sclk_s} = sync_in;
  assign clr    = ~mid_n_s;
  assign shdn_o = shdn_s;

  dac_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_s(cs_s), .sdi_s(sdi_s),
    .cs_rise(cs_rise), .wr_en(wr_en), .wr_cmd(wr_cmd), .bit_cnt(bit_cnt)
  );

  dac_latch_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_cmd(wr_cmd),
    .lat_flat(ch_level)
  );
endmodule

// File: rtl/dac_bank_chk.sv
module dac_bank_chk
  import dac_bank_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clr,
  input logic                     wr_en,
  input dac_cmd_t                 wr_cmd,
  input logic                     cs_rise,
  input logic [CNT_W-1:0]         bit_cnt,
  input logic [NUM_CH*DATA_W-1:0] ch_level
);
  // R8: without a write or half-scale request the bank holds, whatever shutdown does
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr) |=> (ch_level == $past(ch_level)));

  // R7: half-scale request lands 0x80 in every channel
  p_midscale_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ch_level == {NUM_CH{MIDSCALE}}));

  // R6: out-of-range address leaves the bank alone
  p_badaddr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && (int'(wr_cmd.addr) >= NUM_CH) && !clr) |=> (ch_level == $past(ch_level)));

  // R5: a commit after a short frame writes nothing
  p_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && (bit_cnt < CNT_W'(FRAME_W)) && !clr) |=> (ch_level == $past(ch_level)));

  // R4: the bit counter saturates at one frame
  p_cnt_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W));
endmodule

bind dac_serial_bank dac_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_cmd(wr_cmd),
  .cs_rise(cs_rise), .bit_cnt(bit_cnt), .ch_level(ch_level)
);

// File: tb/test_dac_serial_bank.sv
module test_dac_serial_bank;
  localparam int NCH = 12;

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, sdi, mid_rst_n, shdn;
  logic [NCH*8-1:0] ch_level;
  logic shdn_o;

  always #10 clk = ~clk;

  dac_serial_bank i_dac_serial_bank (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .mid_rst_n(mid_rst_n), .shdn(shdn), .ch_level(ch_level), .shdn_o(shdn_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit reported = 0;

  logic [7:0]    mdl [NCH];
  logic          mdl_sd;
  logic [95:0]   q_lv [$];
  logic          q_sd [$];
  string         q_tag [$];

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // driver side: push the expected bank, wait until the monitor consumed it
  task automatic expect_bank(input string tag);
    logic [95:0] v;
    for (int i = 0; i < NCH; i++) v[i*8 +: 8] = mdl[i];
    q_lv.push_back(v);
    q_sd.push_back(mdl_sd);
    q_tag.push_back(tag);
    wait (q_lv.size() == 0);
    ticks(1);
  endtask

  task automatic send_frame(input int nbits, input logic [31:0] word, input string tag);
    cs_n = 1'b0;
    ticks(4);
    for (int b = nbits - 1; b >= 0; b--) begin
      sdi = word[b];
      ticks(4);
      sclk = 1'b1;
      ticks(4);
      sclk = 1'b0;
    end
    ticks(4);
    cs_n = 1'b1;
    ticks(2);
    if (nbits >= 12 && int'(word[11:8]) < NCH) mdl[word[11:8]] = word[7:0];
    expect_bank(tag);
  endtask

  // monitor: compare after the synchronizer and commit latency has passed
  initial begin
    forever begin
      wait (q_lv.size() > 0);
      ticks(10);
      for (int i = 0; i < NCH; i++) begin
        n_chk++;
        if (ch_level[i*8 +: 8] !== q_lv[0][i*8 +: 8]) begin
          n_bad++;
          $display("FAIL %s ch%0d actual=%02h expected=%02h", q_tag[0], i,
                   ch_level[i*8 +: 8], q_lv[0][i*8 +: 8]);
        end
      end
      n_chk++;
      if (shdn_o !== q_sd[0]) begin
        n_bad++;
        $display("FAIL %s shdn_o actual=%b expected=%b", q_tag[0], shdn_o, q_sd[0]);
      end
      void'(q_lv.pop_front());
      void'(q_sd.pop_front());
      void'(q_tag.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0;
    mid_rst_n = 1'b1; shdn = 1'b0;
    for (int i = 0; i < NCH; i++) mdl[i] = 8'h80;
    mdl_sd = 1'b0;
    ticks(5);
    rst_n = 1'b1;
    ticks(2);
    expect_bank("R1");

    // R2: plain 12-bit frames at first, middle and last channel
    send_frame(12, 32'h05A, "R2");
    send_frame(12, 32'hBC3, "R2");
    send_frame(12, 32'h527, "R2");

    // R3: clocking with select high
    sdi = 1'b1;
    for (int k = 0; k < 14; k++) begin
      ticks(4); sclk = 1'b1; ticks(4); sclk = 1'b0;
    end
    sdi = 1'b0;
    expect_bank("R3");

    // R4: longer frames keep only the last 12 bits
    send_frame(16, 32'hF37E, "R4");
    send_frame(16, 32'h2B11, "R4");
    send_frame(20, 32'hAB4D2, "R4");

    // R5: short frame aborted
    send_frame(8, 32'h0AB, "R5");
    send_frame(11, 32'h1EE, "R5");

    // R10: short frame right after a long one
    send_frame(16, 32'h0166, "R10");
    send_frame(8, 32'h2F, "R10");

    // R6: addresses past the last channel
    send_frame(12, 32'hC55, "R6");
    send_frame(12, 32'hD01, "R6");
    send_frame(12, 32'hFFF, "R6");

    // R8: shutdown leaves latches alone
    shdn = 1'b1; mdl_sd = 1'b1;
    expect_bank("R8");
    // R9: writes under shutdown still land
    send_frame(12, 32'h799, "R9");
    send_frame(12, 32'h0E1, "R9");
    shdn = 1'b0; mdl_sd = 1'b0;
    expect_bank("R8");

    // R7: half-scale request, then normal writes resume
    mid_rst_n = 1'b0;
    ticks(4);
    mid_rst_n = 1'b1;
    for (int i = 0; i < NCH; i++) mdl[i] = 8'h80;
    expect_bank("R7");
    send_frame(12, 32'hA3C, "R7");
    send_frame(12, 32'h600, "R2");

    report();
  end
endmodule